// File: doc/BRIEF.md
# Paged management-to-register bridge

This block sits behind a decoded clause-22 management transaction and gives a 16-bit management master access to a wider 32-bit internal register space. Each transaction arrives already decoded as a PHY address, a register number, a single-cycle write strobe with 16-bit data, or a single-cycle read strobe. The bridge answers reads with 16-bit data and drives a plain internal register port carrying an address, a write enable, a read strobe, 32-bit write data and 32-bit read data.

The internal word address is rebuilt from three sources. The upper part comes from a page register that persists between transactions. The middle part comes from the low bits of the PHY address. The lower part comes from the register number. One PHY address is reserved for loading the page register. Eight neighbouring PHY addresses carry data. An even register number selects the lower half of a word and the following odd number selects the upper half.

A 32-bit write is staged. The lower half is held until the matching upper half arrives, and the internal write then fires. A 32-bit read is done at the lower half: the whole word is fetched and the upper half is latched, so that the following upper-half read returns data from the same moment.

Top module: `mdio_page_bridge`

## Requirements
- R1: After reset the page register reads as zero, read data is zero, and no staged write is pending, so an upper-half write before any lower-half write causes no internal write.
- R2: A write to PHY address 0x18, register 0 loads the page register from write data bits [9:0], and bits [15:10] are ignored. A read of that register returns the page zero-extended to 16 bits. Other registers at PHY address 0x18 ignore writes and read as 0x0000.
- R3: During a data access (PHY address 0x10 to 0x17), the internal address is page in bits [18:9], PHY address bits [2:0] in bits [8:6], register number bits [4:1] in bits [5:2], and zero in bits [1:0].
- R4: A data write to an even register number produces no internal write. A following write to the next odd register of the same word raises the write enable in the same cycle, with write data {upper half, staged lower half}, and it clears the staged state.
- R5: An upper-half write raises no write enable when no lower half is staged, or when the staged lower half belongs to a different word.
- R6: A data read of an even register number raises the internal read strobe in that cycle. The cycle after, it returns internal read data bits [15:0].
- R7: A data read of an odd register number raises no internal read strobe. It returns the upper 16 bits latched by the most recent lower-half read, even if the internal word has since changed.
- R8: A transaction to a PHY address outside 0x10 to 0x18 has no effect: no internal write, no page change, and its read returns 0xFFFF.
- R9: The page register keeps its value across any number of data accesses, and a new page value applies to every later access.
- R10: Read data changes only in the cycle after a read strobe, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| phyAddr | input | 5 | PHY address of the transaction |
| regNum | input | 5 | Register number of the transaction |
| wrStb | input | 1 | One-cycle write strobe |
| wrData | input | 16 | Write data |
| rdStb | input | 1 | One-cycle read strobe |
| rdData | output | 16 | Read data, valid from the cycle after rdStb |
| regAddr | output | 19 | Internal word address (byte address, bits [1:0] zero) |
| regWe | output | 1 | Internal 32-bit write enable |
| regRe | output | 1 | Internal 32-bit read strobe |
| regWdata | output | 32 | Internal write data |
| regRdata | input | 32 | Internal read data, combinational from regAddr |

## Verification
The checks assume that a write strobe and a read strobe never arrive in the same cycle. They also assume that the internal read data is a combinational function of the address presented in the strobe cycle. The bench drives each transaction as a single-strobe cycle followed by an idle cycle, and its register model answers reads in the same cycle. On that basis the checks cover the following: write and read enables appear only for the right half of a data access, out-of-range reads return all ones, and read data holds between reads.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;
  localparam logic [4:0] PAGE_PHY  = 5'h18;
  localparam logic [1:0] DATA_HIGH = 2'b10;

  typedef struct packed {
    logic pageWr;
    logic lowWr;
    logic highWr;
    logic lowRd;
    logic highRd;
    logic pageRd;
    logic zeroRd;
    logic badRd;
  } bridgeStb_t;
endpackage

// File: rtl/mdio_bridge_ctrl.sv
module mdio_bridge_ctrl
  import mdio_bridge_pkg::*;
(
  input  logic [4:0] phyAddr,
  input  logic [4:0] regNum,
  input  logic       wrStb,
  input  logic       rdStb,
  output bridgeStb_t stb
);
  logic isData;
  logic isPage;
  logic isPageReg;
  logic isHigh;

  always_comb begin
    isData    = (phyAddr[4:3] == DATA_HIGH);
    isPage    = (phyAddr == PAGE_PHY);
    isPageReg = isPage && (regNum == 5'd0);
    isHigh    = regNum[0];

    stb.pageWr = wrStb && isPageReg;
    stb.lowWr  = wrStb && isData && !isHigh;
    stb.highWr = wrStb && isData && isHigh;
    stb.lowRd  = rdStb && isData && !isHigh;
    stb.highRd = rdStb && isData && isHigh;
    stb.pageRd = rdStb && isPageReg;
    stb.zeroRd = rdStb && isPage && !isPageReg;
    stb.badRd  = rdStb && !isData && !isPage;
  end
endmodule

// File: rtl/mdio_bridge_dpath.sv
module mdio_bridge_dpath
  import mdio_bridge_pkg::*;
#(
  parameter int PAGE_W = 10,
  parameter int HALF_W = 16,
  localparam int ADDR_W = PAGE_W + 9,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  bridgeStb_t        stb,
  input  logic [2:0]        phyLow,
  input  logic [4:0]        regNum,
  input  logic [HALF_W-1:0] wrData,
  input  logic [WORD_W-1:0] regRdata,
  output logic [HALF_W-1:0] rdData,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWe,
  output logic              regRe,
  output logic [WORD_W-1:0] regWdata
);
  logic [PAGE_W-1:0] page;
  logic              pending;
  logic [ADDR_W-1:0] stagedAddr;
  logic [HALF_W-1:0] stagedLo;
  logic [HALF_W-1:0] hiLatch;
  logic [ADDR_W-1:0] wordAddr;
  logic              stageMatch;

  always_comb begin
    wordAddr   = {page, phyLow, regNum[4:1], 2'b00};
    stageMatch = pending && (stagedAddr == wordAddr);
    regAddr    = wordAddr;
    regWe      = stb.highWr && stageMatch;
    regRe      = stb.lowRd;
    regWdata   = {wrData, stagedLo};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      page       <= '0;
      pending    <= 1'b0;
      stagedAddr <= '0;
      stagedLo   <= '0;
      hiLatch    <= '0;
      rdData     <= '0;
    end else begin
      if (stb.pageWr) page <= wrData[PAGE_W-1:0];
      if (stb.lowWr) begin
        pending    <= 1'b1;
        stagedAddr <= wordAddr;
        stagedLo   <= wrData;
      end else if (regWe) begin
        pending <= 1'b0;
      end
      if (stb.lowRd) begin
        rdData  <= regRdata[HALF_W-1:0];
        hiLatch <= regRdata[WORD_W-1:HALF_W];
      end else if (stb.highRd) begin
        rdData <= hiLatch;
      end else if (stb.pageRd) begin
        rdData <= {{(HALF_W-PAGE_W){1'b0}}, page};
      end else if (stb.zeroRd) begin
        rdData <= '0;
      end else if (stb.badRd) begin
        rdData <= '1;
      end
    end
  end
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int PAGE_W = 10,
  localparam int ADDR_W = PAGE_W + 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        phyAddr,
  input  logic [4:0]        regNum,
  input  logic              wrStb,
  input  logic [15:0]       wrData,
  input  logic              rdStb,
  output logic [15:0]       rdData,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWe,
  output logic              regRe,
  output logic [31:0]       regWdata,
  input  logic [31:0]       regRdata
);
  bridgeStb_t stb;

  mdio_bridge_ctrl u_ctrl (
    .phyAddr(phyAddr),
    .regNum (regNum),
    .wrStb  (wrStb),
    .rdStb  (rdStb),
    .stb    (stb)
  );

  mdio_bridge_dpath #(.PAGE_W(PAGE_W), .HALF_W(16)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .phyLow  (phyAddr[2:0]),
    .regNum  (regNum),
    .wrData  (wrData),
    .regRdata(regRdata),
    .rdData  (rdData),
    .regAddr (regAddr),
    .regWe   (regWe),
    .regRe   (regRe),
    .regWdata(regWdata)
  );
endmodule

// File: rtl/mdio_page_bridge_chk.sv
module mdio_page_bridge_chk (
  input logic        clk,
  input logic        rstN,
  input logic [4:0]  phyAddr,
  input logic [4:0]  regNum,
  input logic        wrStb,
  input logic        rdStb,
  input logic [15:0] rdData,
  input logic        regWe,
  input logic        regRe
);
  logic inData;
  logic inRange;
  assign inData  = (phyAddr >= 5'h10) && (phyAddr <= 5'h17);
  assign inRange = inData || (phyAddr == 5'h18);

  // input assumption: one strobe per cycle
  single_stb_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrStb && rdStb));

  // R4
  we_on_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> (wrStb && regNum[0] && inData));

  // R6
  re_on_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRe |-> (rdStb && !regNum[0] && inData));

  // R7
  no_re_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && inData && regNum[0]) |-> !regRe);

  // R8
  bad_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && !inRange) |=> (rdData == 16'hFFFF));

  // R8
  bad_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && !inRange) |-> !regWe);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb |=> $stable(rdData));
endmodule

bind mdio_page_bridge mdio_page_bridge_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .phyAddr(phyAddr),
  .regNum (regNum),
  .wrStb  (wrStb),
  .rdStb  (rdStb),
  .rdData (rdData),
  .regWe  (regWe),
  .regRe  (regRe)
);

// File: tb/mdio_page_bridge_bench.sv
module mdio_page_bridge_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  phyAddr = '0;
  logic [4:0]  regNum = '0;
  logic        wrStb = 1'b0;
  logic [15:0] wrData = '0;
  logic        rdStb = 1'b0;
  logic [15:0] rdData;
  logic [18:0] regAddr;
  logic        regWe;
  logic        regRe;
  logic [31:0] regWdata;
  logic [31:0] regRdata;

  logic [31:0] mem [256];
  int total = 0;
  int bad = 0;

  logic        weSeen;
  logic        reSeen;
  logic [18:0] addrSeen;
  logic [31:0] wdSeen;
  logic [15:0] rdSeen;

  always #2.5 clk = ~clk;

  mdio_page_bridge u_mdio_page_bridge (
    .clk(clk), .rstN(rstN), .phyAddr(phyAddr), .regNum(regNum),
    .wrStb(wrStb), .wrData(wrData), .rdStb(rdStb), .rdData(rdData),
    .regAddr(regAddr), .regWe(regWe), .regRe(regRe),
    .regWdata(regWdata), .regRdata(regRdata)
  );

  assign regRdata = mem[regAddr[9:2]];

  always @(posedge clk) if (regWe) mem[regAddr[9:2]] = regWdata;

  function automatic logic [18:0] expAddr(logic [9:0] pg, logic [4:0] phy, logic [4:0] rn);
    return {pg, phy[2:0], rn[4:1], 2'b00};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mWrite(input logic [4:0] phy, input logic [4:0] rn, input logic [15:0] d);
    @(negedge clk);
    phyAddr = phy; regNum = rn; wrData = d; wrStb = 1'b1;
    #1;
    weSeen = regWe; addrSeen = regAddr; wdSeen = regWdata;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic mRead(input logic [4:0] phy, input logic [4:0] rn);
    @(negedge clk);
    phyAddr = phy; regNum = rn; rdStb = 1'b1;
    #1;
    reSeen = regRe; addrSeen = regAddr;
    @(negedge clk);
    rdStb = 1'b0;
    #1;
    rdSeen = rdData;
  endtask

  task automatic testReset();
    check(rdData == 16'h0, "R1 rdData after reset", 32'(rdData), 32'h0);
    mRead(5'h18, 5'd0);
    check(rdSeen == 16'h0, "R1 page after reset", 32'(rdSeen), 32'h0);
    mWrite(5'h10, 5'd1, 16'h7777);
    check(weSeen == 1'b0, "R1 no pending after reset", 32'(weSeen), 32'h0);
  endtask

  task automatic testPage();
    mWrite(5'h18, 5'd0, 16'hFFA5);
    mRead(5'h18, 5'd0);
    check(rdSeen == 16'h03A5, "R2 page readback", 32'(rdSeen), 32'h03A5);
    mWrite(5'h18, 5'd3, 16'h1111);
    mRead(5'h18, 5'd3);
    check(rdSeen == 16'h0, "R2 other page-phy reg reads zero", 32'(rdSeen), 32'h0);
    mRead(5'h18, 5'd0);
    check(rdSeen == 16'h03A5, "R2 other reg write ignored", 32'(rdSeen), 32'h03A5);
  endtask

  task automatic testWritePair();
    mWrite(5'h13, 5'd6, 16'h1234);
    check(weSeen == 1'b0, "R4 low half stages only", 32'(weSeen), 32'h0);
    mWrite(5'h13, 5'd7, 16'hABCD);
    check(weSeen == 1'b1, "R4 high half fires write", 32'(weSeen), 32'h1);
    check(addrSeen == expAddr(10'h3A5, 5'h13, 5'd7), "R3 write address",
          32'(addrSeen), 32'(expAddr(10'h3A5, 5'h13, 5'd7)));
    check(wdSeen == 32'hABCD1234, "R4 assembled word", wdSeen, 32'hABCD1234);
    mWrite(5'h13, 5'd7, 16'hEEEE);
    check(weSeen == 1'b0, "R4 staged state cleared", 32'(weSeen), 32'h0);
  endtask

  task automatic testMismatch();
    mWrite(5'h11, 5'd8, 16'h4444);
    mWrite(5'h11, 5'd11, 16'h5555);
    check(weSeen == 1'b0, "R5 mismatched word no write", 32'(weSeen), 32'h0);
    mWrite(5'h12, 5'd9, 16'h5555);
    check(weSeen == 1'b0, "R5 other phy no write", 32'(weSeen), 32'h0);
  endtask

  task automatic testReadPair();
    mRead(5'h13, 5'd6);
    check(reSeen == 1'b1, "R6 low read strobes", 32'(reSeen), 32'h1);
    check(addrSeen == expAddr(10'h3A5, 5'h13, 5'd6), "R3 read address",
          32'(addrSeen), 32'(expAddr(10'h3A5, 5'h13, 5'd6)));
    check(rdSeen == 16'h1234, "R6 low read data", 32'(rdSeen), 32'h1234);
    mem[expAddr(10'h3A5, 5'h13, 5'd6) >> 2 & 19'hFF] = 32'h55556666;
    mRead(5'h13, 5'd7);
    check(reSeen == 1'b0, "R7 high read no strobe", 32'(reSeen), 32'h0);
    check(rdSeen == 16'hABCD, "R7 latched upper half", 32'(rdSeen), 32'hABCD);
    repeat (3) @(negedge clk);
    check(rdData == 16'hABCD, "R10 read data holds", 32'(rdData), 32'hABCD);
  endtask

  task automatic testOutOfRange();
    mWrite(5'h05, 5'd0, 16'h0001);
    check(weSeen == 1'b0, "R8 out-of-range write no effect", 32'(weSeen), 32'h0);
    mRead(5'h18, 5'd0);
    check(rdSeen == 16'h03A5, "R8 page unchanged", 32'(rdSeen), 32'h03A5);
    mRead(5'h05, 5'd0);
    check(rdSeen == 16'hFFFF, "R8 read all ones", 32'(rdSeen), 32'hFFFF);
    mRead(5'h19, 5'd2);
    check(rdSeen == 16'hFFFF, "R8 read all ones above", 32'(rdSeen), 32'hFFFF);
    mWrite(5'h02, 5'd6, 16'h9999);
    mWrite(5'h02, 5'd7, 16'h9999);
    check(weSeen == 1'b0, "R8 out-of-range pair no write", 32'(weSeen), 32'h0);
  endtask

  task automatic testPersist();
    mWrite(5'h10, 5'd0, 16'h0A0A);
    mWrite(5'h10, 5'd1, 16'h0B0B);
    check(addrSeen == expAddr(10'h3A5, 5'h10, 5'd1), "R9 page kept first",
          32'(addrSeen), 32'(expAddr(10'h3A5, 5'h10, 5'd1)));
    mWrite(5'h17, 5'd30, 16'h0C0C);
    mWrite(5'h17, 5'd31, 16'h0D0D);
    check(weSeen && addrSeen == expAddr(10'h3A5, 5'h17, 5'd31), "R9 page kept second",
          32'(addrSeen), 32'(expAddr(10'h3A5, 5'h17, 5'd31)));
    mWrite(5'h18, 5'd0, 16'h0002);
    mWrite(5'h10, 5'd0, 16'h1010);
    mWrite(5'h10, 5'd1, 16'h2020);
    check(weSeen && addrSeen == expAddr(10'h002, 5'h10, 5'd1), "R9 new page applies",
          32'(addrSeen), 32'(expAddr(10'h002, 5'h10, 5'd1)));
    mRead(5'h10, 5'd0);
    check(rdSeen == 16'h1010, "R6 read new page word", 32'(rdSeen), 32'h1010);
    mRead(5'h10, 5'd1);
    check(rdSeen == 16'h2020, "R7 read new page upper", 32'(rdSeen), 32'h2020);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPage();
    testWritePair();
    testMismatch();
    testReadPair();
    testOutOfRange();
    testPersist();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule